// File: doc/BRIEF.md
# Banked Read-Modify-Write Counter Engine

This engine keeps packet and byte counters in an external dual-port, double-data-rate SRAM and updates them for four request channels that share the memory. A request names one counter entry and carries a packet increment and a byte increment. The engine turns each accepted request into a read on port A. When the read data comes back it adds the saved increments to the two fields and writes the result back on port B. Because reads use port A and write-backs use port B, a new read and an older write-back can go out in the same clock, so the engine sustains one counter update per cycle.

Channels are served by a slot wheel in a fixed order that depends on the memory mode. In round mode the wheel visits channels in plain numeric order. In banked mode the memory has eight banks, selected by the three lowest address bits, and the wheel visits the even channels before the odd ones. In banked mode a read that would hit the same bank as the read one cycle earlier is held back by one bubble cycle. A request whose entry still has an update in flight is left waiting until its entry has been written back, so no increment is ever lost.

Top module: `rmw_cnt_engine`

## Requirements
- R1: Each accepted request causes a read of its address on port A in the next cycle. Exactly RD_LAT+1 cycles after that read appears, a write to the same address appears on port B. No write appears without such a read.
- R2: A stored word holds the packet count in bits [31:0] and the byte count in bits [71:32]. The written word is the returned word with the packet increment added to the packet field and the byte increment added to the byte field. Each field wraps modulo its own width, and no carry passes from one field into the other.
- R3: With `bank_mode`=0 and all four channels requesting from reset, requests are accepted from channels 0, 1, 2, 3 in four consecutive cycles, starting in the first cycle after reset.
- R4: With `bank_mode`=1 and all four channels requesting from reset, with no bank clashes, requests are accepted from channels 0, 2, 1, 3 in four consecutive cycles.
- R5: With `bank_mode`=1, a read never has the same address bits [2:0] as a read issued in the cycle before it. A request whose turn would cause such a clash waits one bubble cycle and is then accepted, and the wheel keeps its position during the bubble. With `bank_mode`=0 the same addresses cause no delay.
- R6: At most one channel is accepted per cycle, and `req_ready` is never high for a channel whose `req_valid` is low.
- R7: Once a read of an address has been issued, no new read of that address is issued within the following RD_LAT+1 cycles. A blocked channel loses its turn, the wheel moves on, and the channel is accepted on its first turn after the window has passed. Both increments end up in the stored word.
- R8: While reset is asserted, and with no requests, `mem_rd_en`, `mem_wr_en` and `req_ready` are all low.
- R9: The wheel advances one slot per cycle even when the channel owning the slot has no request. A lone requester is accepted only when its own slot comes up: cycle 3 for channel 3 in round mode, and cycle 2 for channel 1 in banked mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_mode | input | 1 | 0: round order; 1: banked order with bank-clash bubbles |
| req_valid | input | NCH | Per-channel request valid |
| req_ready | output | NCH | Per-channel acceptance, one-hot or zero |
| req_addr | input | NCH*ADDR_W | Per-channel counter address, channel c in slice c |
| req_pkt_inc | input | NCH*INC_W | Per-channel packet increment |
| req_byte_inc | input | NCH*INC_W | Per-channel byte increment |
| mem_rd_en | output | 1 | Port A read command |
| mem_rd_addr | output | ADDR_W | Port A read address |
| mem_rd_data | input | PKT_W+BYTE_W | Read data, valid RD_LAT cycles after the read command |
| mem_wr_en | output | 1 | Port B write command |
| mem_wr_addr | output | ADDR_W | Port B write address |
| mem_wr_data | output | PKT_W+BYTE_W | Port B write data |

## Verification
The properties take for granted that a requester holds its valid, address and increments steady until it is accepted. They also assume that the memory returns the word for a read exactly RD_LAT cycles after the read command, and that `bank_mode` changes only while reset is asserted. The stimulus meets these conditions in three ways. Each channel keeps a pending request until it sees `req_ready`, the memory model delivers read data through a delay line RD_LAT stages long, and the mode is changed only inside a reset sequence. Random addresses are drawn from a small window so that bank clashes and same-entry overlaps happen often.

// File: rtl/rmw_cnt_pkg.sv
package rmw_cnt_pkg;

    typedef enum logic {
        ORDER_ROUND      = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

    // Maps a wheel position to a channel number. Interleave visits all even
    // channels first, then all odd ones (nch must be even).
    function automatic int unsigned slot_to_chan(input order_e ord,
                                                 input int unsigned slot,
                                                 input int unsigned nch);
        int unsigned half;
        half = nch / 2;
        if (ord == ORDER_ROUND) begin
            return slot;
        end
        if (slot < half) begin
            return 2 * slot;
        end
        return 2 * (slot - half) + 1;
    endfunction

endpackage

// File: rtl/rmw_slot_sched.sv
module rmw_slot_sched
    import rmw_cnt_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int BANK_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bank_mode,
    input  logic [NCH-1:0]        req_valid,
    input  logic [NCH*ADDR_W-1:0] req_addr,
    input  logic [NCH-1:0]        busy,
    input  logic                  prev_rd_valid,
    input  logic [BANK_W-1:0]     prev_rd_bank,
    output logic [NCH-1:0]        grant,
    output logic                  grant_valid
);

    localparam int SLOT_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } wheel_t;

    wheel_t st_d, st_q;

    order_e            ord;
    logic [SLOT_W-1:0] chan;
    logic [ADDR_W-1:0] cand_addr;
    logic              clash;
    logic              advance;

    always_comb begin
        st_d        = st_q;
        grant       = '0;
        grant_valid = 1'b0;
        ord         = bank_mode ? ORDER_INTERLEAVE : ORDER_ROUND;
        chan        = SLOT_W'(slot_to_chan(ord, 32'(st_q.slot), NCH));
        cand_addr   = req_addr[chan*ADDR_W +: ADDR_W];
        clash       = bank_mode && prev_rd_valid &&
                      (cand_addr[BANK_W-1:0] == prev_rd_bank);
        advance     = 1'b1;

        if (req_valid[chan] && !busy[chan]) begin
            if (clash) begin
                // one bubble; the same channel retries next cycle
                advance = 1'b0;
            end else begin
                grant[chan] = 1'b1;
                grant_valid = 1'b1;
            end
        end

        if (advance) begin
            st_d.slot = (st_q.slot == SLOT_W'(NCH - 1)) ? '0
                                                        : st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rmw_flight_track.sv
module rmw_flight_track #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int INC_W  = 16,
    parameter int PKT_W  = 32,
    parameter int BYTE_W = 40,
    parameter int RD_LAT = 5,
    parameter int BANK_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue_valid,
    input  logic [ADDR_W-1:0]         issue_addr,
    input  logic [INC_W-1:0]          issue_pkt_inc,
    input  logic [INC_W-1:0]          issue_byte_inc,
    input  logic [NCH*ADDR_W-1:0]     req_addr,
    input  logic [PKT_W+BYTE_W-1:0]   mem_rd_data,
    output logic [NCH-1:0]            busy,
    output logic                      prev_rd_valid,
    output logic [BANK_W-1:0]         prev_rd_bank,
    output logic                      mem_rd_en,
    output logic [ADDR_W-1:0]         mem_rd_addr,
    output logic                      mem_wr_en,
    output logic [ADDR_W-1:0]         mem_wr_addr,
    output logic [PKT_W+BYTE_W-1:0]   mem_wr_data
);

    localparam int WORD_W = PKT_W + BYTE_W;
    localparam int STAGES = RD_LAT + 1;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [INC_W-1:0]  pkt_inc;
        logic [INC_W-1:0]  byte_inc;
    } flight_t;

    typedef struct packed {
        flight_t [STAGES-1:0] pipe;
        logic                 wr_en;
        logic [ADDR_W-1:0]    wr_addr;
        logic [WORD_W-1:0]    wr_data;
    } track_t;

    track_t  st_d, st_q;
    flight_t done;
    logic [PKT_W-1:0]  sum_pkt;
    logic [BYTE_W-1:0] sum_byte;

    // entry in the last stage meets its returning read data
    assign done     = st_q.pipe[STAGES-1];
    assign sum_pkt  = mem_rd_data[PKT_W-1:0] + PKT_W'(done.pkt_inc);
    assign sum_byte = mem_rd_data[WORD_W-1:PKT_W] + BYTE_W'(done.byte_inc);

    always_comb begin
        st_d = st_q;
        st_d.pipe[0].valid    = issue_valid;
        st_d.pipe[0].addr     = issue_addr;
        st_d.pipe[0].pkt_inc  = issue_pkt_inc;
        st_d.pipe[0].byte_inc = issue_byte_inc;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.wr_en = done.valid;
        if (done.valid) begin
            st_d.wr_addr = done.addr;
            st_d.wr_data = {sum_byte, sum_pkt};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // per-channel match against every entry still awaiting write-back
    for (genvar c = 0; c < NCH; c++) begin : g_busy
        logic [STAGES-1:0] hit;
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            assign hit[s] = st_q.pipe[s].valid &&
                            (st_q.pipe[s].addr == req_addr[c*ADDR_W +: ADDR_W]);
        end
        assign busy[c] = |hit;
    end

    assign prev_rd_valid = st_q.pipe[0].valid;
    assign prev_rd_bank  = st_q.pipe[0].addr[BANK_W-1:0];
    assign mem_rd_en     = st_q.pipe[0].valid;
    assign mem_rd_addr   = st_q.pipe[0].addr;
    assign mem_wr_en     = st_q.wr_en;
    assign mem_wr_addr   = st_q.wr_addr;
    assign mem_wr_data   = st_q.wr_data;

endmodule

// File: rtl/rmw_cnt_engine.sv
module rmw_cnt_engine #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int INC_W  = 16,
    parameter int PKT_W  = 32,
    parameter int BYTE_W = 40,
    parameter int RD_LAT = 5,
    parameter int BANK_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bank_mode,
    input  logic [NCH-1:0]          req_valid,
    output logic [NCH-1:0]          req_ready,
    input  logic [NCH*ADDR_W-1:0]   req_addr,
    input  logic [NCH*INC_W-1:0]    req_pkt_inc,
    input  logic [NCH*INC_W-1:0]    req_byte_inc,
    output logic                    mem_rd_en,
    output logic [ADDR_W-1:0]       mem_rd_addr,
    input  logic [PKT_W+BYTE_W-1:0] mem_rd_data,
    output logic                    mem_wr_en,
    output logic [ADDR_W-1:0]       mem_wr_addr,
    output logic [PKT_W+BYTE_W-1:0] mem_wr_data
);

    logic [NCH-1:0]    grant;
    logic              grant_valid;
    logic [NCH-1:0]    busy;
    logic              prev_rd_valid;
    logic [BANK_W-1:0] prev_rd_bank;
    logic [ADDR_W-1:0] issue_addr;
    logic [INC_W-1:0]  issue_pkt_inc;
    logic [INC_W-1:0]  issue_byte_inc;

    rmw_slot_sched #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W)
    ) sched_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bank_mode     (bank_mode),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .busy          (busy),
        .prev_rd_valid (prev_rd_valid),
        .prev_rd_bank  (prev_rd_bank),
        .grant         (grant),
        .grant_valid   (grant_valid)
    );

    // 4:1 request multiplex driven by the one-hot grant
    always_comb begin
        issue_addr     = '0;
        issue_pkt_inc  = '0;
        issue_byte_inc = '0;
        for (int c = 0; c < NCH; c++) begin
            if (grant[c]) begin
                issue_addr     = req_addr[c*ADDR_W +: ADDR_W];
                issue_pkt_inc  = req_pkt_inc[c*INC_W +: INC_W];
                issue_byte_inc = req_byte_inc[c*INC_W +: INC_W];
            end
        end
    end

    assign req_ready = grant;

    rmw_flight_track #(
        .NCH    (NCH),
        .ADDR_W (ADDR_W),
        .INC_W  (INC_W),
        .PKT_W  (PKT_W),
        .BYTE_W (BYTE_W),
        .RD_LAT (RD_LAT),
        .BANK_W (BANK_W)
    ) track_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .issue_valid    (grant_valid),
        .issue_addr     (issue_addr),
        .issue_pkt_inc  (issue_pkt_inc),
        .issue_byte_inc (issue_byte_inc),
        .req_addr       (req_addr),
        .mem_rd_data    (mem_rd_data),
        .busy           (busy),
        .prev_rd_valid  (prev_rd_valid),
        .prev_rd_bank   (prev_rd_bank),
        .mem_rd_en      (mem_rd_en),
        .mem_rd_addr    (mem_rd_addr),
        .mem_wr_en      (mem_wr_en),
        .mem_wr_addr    (mem_wr_addr),
        .mem_wr_data    (mem_wr_data)
    );

endmodule

// File: rtl/rmw_cnt_checker.sv
module rmw_cnt_checker #(
    parameter int NCH    = 4,
    parameter int ADDR_W = 10,
    parameter int BANK_W = 3,
    parameter int RD_LAT = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_mode,
    input logic [NCH-1:0]    req_valid,
    input logic [NCH-1:0]    req_ready,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr
);

    // history of reads: index k holds the read from k+1 cycles ago
    logic [RD_LAT:0]             hv;
    logic [RD_LAT:0][ADDR_W-1:0] ha;
    logic                        recent_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hv <= '0;
            ha <= '0;
        end else begin
            hv <= {hv[RD_LAT-1:0], mem_rd_en};
            ha <= {ha[RD_LAT-1:0], mem_rd_addr};
        end
    end

    always_comb begin
        recent_hit = 1'b0;
        for (int k = 0; k <= RD_LAT; k++) begin
            if (hv[k] && (ha[k] == mem_rd_addr)) begin
                recent_hit = 1'b1;
            end
        end
    end

    assert_single_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready) && ((req_ready & ~req_valid) == '0));

    assert_wb_follows_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en == hv[RD_LAT]) && (!mem_wr_en || (mem_wr_addr == ha[RD_LAT])));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !recent_hit);

    assert_bank_spread_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_mode && mem_rd_en && hv[0]) |->
            (mem_rd_addr[BANK_W-1:0] != ha[0][BANK_W-1:0]));

endmodule

bind rmw_cnt_engine rmw_cnt_checker #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .RD_LAT (RD_LAT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_mode   (bank_mode),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr)
);

// File: tb/rmw_cnt_engine_tb_top.sv
`timescale 1ns/1ps
module rmw_cnt_engine_tb_top;

    localparam int NCH = 4, AW = 10, IW = 16, PW = 32, BW = 40, LAT = 5;
    localparam int WW = PW + BW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bank_mode = 1'b0;
    logic [NCH-1:0]    req_valid = '0;
    logic [NCH-1:0]    req_ready;
    logic [NCH*AW-1:0] req_addr = '0;
    logic [NCH*IW-1:0] req_pkt_inc = '0;
    logic [NCH*IW-1:0] req_byte_inc = '0;
    logic              mem_rd_en, mem_wr_en;
    logic [AW-1:0]     mem_rd_addr, mem_wr_addr;
    logic [WW-1:0]     mem_rd_data, mem_wr_data;

    always #2.5 clk = ~clk;

    rmw_cnt_engine dut_i (
        .clk(clk), .rst_n(rst_n), .bank_mode(bank_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_pkt_inc(req_pkt_inc), .req_byte_inc(req_byte_inc),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // behavioural memory: read data after LAT cycles, writes on port B
    logic [WW-1:0] mem [DEPTH];
    logic [WW-1:0] rdq [LAT];
    logic          clr = 1'b0, pl_en = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [WW-1:0] pl_val = '0;

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (pl_en) begin
            mem[pl_addr] <= pl_val;
        end else if (mem_wr_en) begin
            mem[mem_wr_addr] <= mem_wr_data;
        end
        rdq[0] <= mem[mem_rd_addr];
        for (int j = 1; j < LAT; j++) rdq[j] <= rdq[j-1];
    end
    assign mem_rd_data = rdq[LAT-1];

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    logic [WW-1:0] ref_mem [DEPTH];
    logic [NCH-1:0] pv;
    logic [AW-1:0]  pa [NCH];
    logic [IW-1:0]  ppi [NCH], pbi [NCH];
    int             acc_cyc [NCH];
    logic           ew_v [16];
    logic [AW-1:0]  ew_a [16];
    logic [WW-1:0]  ew_d [16];
    logic           la_v;
    logic [AW-1:0]  la_a;
    logic [IW-1:0]  la_pi, la_bi;
    logic           prv_v;
    logic [AW-1:0]  prv_a;

    function automatic logic [WW-1:0] upd(input logic [WW-1:0] w,
                                          input logic [IW-1:0] pi, input logic [IW-1:0] bi);
        logic [PW-1:0] p;
        logic [BW-1:0] b;
        p = w[PW-1:0] + PW'(pi);
        b = w[WW-1:PW] + BW'(bi);
        return {b, p};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        logic [NCH-1:0] acc;
        int s;
        for (int c = 0; c < NCH; c++) begin
            req_addr[c*AW +: AW]     = pa[c];
            req_pkt_inc[c*IW +: IW]  = ppi[c];
            req_byte_inc[c*IW +: IW] = pbi[c];
        end
        req_valid = pv;
        #1;
        s = cyc % 16;
        if (ew_v[s])
            check(mem_wr_en && mem_wr_addr == ew_a[s] && mem_wr_data == ew_d[s],
                  "R1 R2 write-back", {mem_wr_en, mem_wr_addr, mem_wr_data[59:0]},
                  {1'b1, ew_a[s], ew_d[s][59:0]});
        else if (mem_wr_en)
            check(0, "R1 stray write", WW'(mem_wr_addr), '0);
        ew_v[s] = 0;
        if (mem_rd_en) begin
            check(la_v && mem_rd_addr == la_a, "R1 read address", WW'(mem_rd_addr), WW'(la_a));
            s = (cyc + LAT + 1) % 16;
            ew_v[s] = 1;
            ew_a[s] = mem_rd_addr;
            ew_d[s] = upd(mem[mem_rd_addr], la_pi, la_bi);
            if (bank_mode && prv_v)
                check(mem_rd_addr[2:0] != prv_a[2:0], "R5 same bank back to back",
                      WW'(mem_rd_addr), WW'(prv_a));
        end else if (la_v) begin
            check(0, "R1 missing read", '0, WW'(la_a));
        end
        prv_v = mem_rd_en;
        prv_a = mem_rd_addr;
        la_v = 0;
        if ($countones(req_ready) > 1 || (req_ready & ~req_valid) != '0)
            check(0, "R6 acceptance", WW'(req_ready), WW'(req_valid));
        acc = req_ready & req_valid;
        for (int c = 0; c < NCH; c++) begin
            if (acc[c]) begin
                ref_mem[pa[c]] = upd(ref_mem[pa[c]], ppi[c], pbi[c]);
                la_v = 1; la_a = pa[c]; la_pi = ppi[c]; la_bi = pbi[c];
                acc_cyc[c] = cyc;
                pv[c] = 0;
            end
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 0;
        pv = '0;
        req_valid = '0;
        bank_mode = mode;
        la_v = 0; prv_v = 0;
        for (int i = 0; i < 16; i++) ew_v[i] = 0;
        for (int c = 0; c < NCH; c++) begin
            acc_cyc[c] = -1; pa[c] = '0; ppi[c] = '0; pbi[c] = '0;
        end
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        @(negedge clk);
        clr = 1;
        @(negedge clk);
        clr = 0;
        @(negedge clk);
    endtask

    task automatic release_reset();
        rst_n = 1;
        cyc = 0;
    endtask

    task automatic preload(input logic [AW-1:0] a, input logic [WW-1:0] v);
        pl_addr = a; pl_val = v; pl_en = 1;
        @(negedge clk);
        pl_en = 0;
        ref_mem[a] = v;
    endtask

    task automatic put(input int c, input logic [AW-1:0] a,
                       input logic [IW-1:0] pi, input logic [IW-1:0] bi);
        pv[c] = 1; pa[c] = a; ppi[c] = pi; pbi[c] = bi;
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && pv != '0; i++) step();
        repeat (LAT + 4) step();
    endtask

    task automatic expect_acc(input int c, input int exp, input string tag);
        check(acc_cyc[c] == exp, tag, WW'(acc_cyc[c]), WW'(exp));
    endtask

    task automatic compare_window(input string tag);
        for (int a = 0; a < 32; a++)
            check(mem[a] == ref_mem[a], tag, mem[a], ref_mem[a]);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        do_reset(1'b0);
        // R8: idle outputs while in reset
        check(!mem_rd_en && !mem_wr_en && req_ready == '0, "R8 reset outputs",
              {mem_rd_en, mem_wr_en, req_ready}, '0);

        // R3: round order
        for (int c = 0; c < NCH; c++) put(c, AW'(16 + c), IW'(c + 1), IW'(100));
        release_reset();
        drain();
        for (int c = 0; c < NCH; c++) expect_acc(c, c, "R3 round order");

        // R4: interleaved order 0,2,1,3
        do_reset(1'b1);
        for (int c = 0; c < NCH; c++) put(c, AW'(16 + c), IW'(7), IW'(64));
        release_reset();
        drain();
        expect_acc(0, 0, "R4 interleave ch0");
        expect_acc(2, 1, "R4 interleave ch2");
        expect_acc(1, 2, "R4 interleave ch1");
        expect_acc(3, 3, "R4 interleave ch3");

        // R5: bank clash bubble in banked mode (0x21 and 0x09 share bank 1)
        do_reset(1'b1);
        put(0, 10'h021, 1, 1); put(2, 10'h009, 2, 2);
        put(1, 10'h002, 3, 3); put(3, 10'h004, 4, 4);
        release_reset();
        drain();
        expect_acc(0, 0, "R5 banked ch0");
        expect_acc(2, 2, "R5 banked bubble ch2");
        expect_acc(1, 3, "R5 banked ch1");
        expect_acc(3, 4, "R5 banked ch3");

        // R5: round mode shows no delay for the same bank pattern
        do_reset(1'b0);
        put(0, 10'h021, 1, 1); put(1, 10'h009, 2, 2);
        put(2, 10'h002, 3, 3); put(3, 10'h004, 4, 4);
        release_reset();
        drain();
        expect_acc(1, 1, "R5 round no bubble ch1");
        expect_acc(3, 3, "R5 round no bubble ch3");

        // R7: same entry from two channels
        do_reset(1'b0);
        put(0, 10'h030, 16'd5, 16'd500); put(1, 10'h030, 16'd9, 16'd900);
        put(2, 10'h031, 1, 1); put(3, 10'h032, 1, 1);
        release_reset();
        drain();
        begin
            int exp1;
            exp1 = 1;
            while (exp1 <= 1 + LAT) exp1 += NCH;
            expect_acc(1, exp1, "R7 held until write-back");
        end
        check(mem[10'h030] == {40'd1400, 32'd14}, "R7 both increments kept",
              mem[10'h030], {40'd1400, 32'd14});

        // R9: lone requesters wait for their own slot
        do_reset(1'b0);
        put(3, 10'h005, 1, 1);
        release_reset();
        drain();
        expect_acc(3, 3, "R9 round lone ch3");
        do_reset(1'b1);
        put(1, 10'h005, 1, 1);
        release_reset();
        drain();
        expect_acc(1, 2, "R9 banked lone ch1");

        // R2: field wrap with no carry between fields
        do_reset(1'b0);
        preload(10'h040, {{BW{1'b1}}, {PW{1'b1}}});
        preload(10'h041, {40'd5, {PW{1'b1}}});
        put(0, 10'h040, 16'd1, 16'd1);
        put(1, 10'h041, 16'd2, 16'd3);
        release_reset();
        drain();
        check(mem[10'h040] == '0, "R2 both fields wrap", mem[10'h040], '0);
        check(mem[10'h041] == {40'd8, 32'd1}, "R2 packet wrap only",
              mem[10'h041], {40'd8, 32'd1});

        // random traffic in both modes, small address window
        for (int m = 0; m < 2; m++) begin
            do_reset(m[0]);
            release_reset();
            for (int n = 0; n < 3000; n++) begin
                for (int c = 0; c < NCH; c++)
                    if (!pv[c] && ($urandom % 100) < 60)
                        put(c, AW'($urandom % 32), IW'($urandom), IW'($urandom));
                step();
            end
            drain();
            compare_window(m == 0 ? "R2 R7 random round" : "R2 R7 random banked");
        end

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule